// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block runs the atomic memory instructions of a sandboxed virtual-machine instruction set against a plain synchronous memory port. When `start` is pulsed, it takes the instruction opcode, the 16-bit offset and the 32-bit immediate, together with the current values of the destination register, the source register and R0. It then checks the encoding and the alignment. For a legal instruction it holds a lock on memory, reads the addressed word, computes the update and writes it back, unless a compare-and-exchange fails to match, in which case it skips the write.

The effective address is the destination register plus the sign-extended offset. The immediate selects one of these operations:
- add, or, and, xor, each with an optional fetch;
- exchange;
- compare-and-exchange against R0.

The opcode selects either a 32-bit access or a 64-bit access. On completion the block raises `done` for one cycle. In that cycle it may present the old memory value, zero-extended, as a write-back for the source register or for R0.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Only opcode 0xC3 (class field bits 2:0 = 3, mode field bits 7:5 = 6, size field bits 4:3 = 0, 32-bit) and opcode 0xDB (size field = 3, 64-bit) are accepted. Any other opcode, including the byte and half-word sizes, ends with `err` and makes no memory access.
- R2: Legal immediates have bits 31:8 clear and a low byte from this set: 0x00 add, 0x40 or, 0x50 and, 0xA0 xor, each optionally with bit 0 (fetch) set, plus 0xE1 exchange and 0xF1 compare-and-exchange. Any other immediate ends with `err` and makes no memory access.
- R3: `mem_addr` equals the destination value plus the sign-extended offset. If that address is not a multiple of 4 (32-bit) or 8 (64-bit), the operation ends with `err` and makes no memory access.
- R4: For a legal operation that writes:
  - a read request appears in the first cycle after the `start` edge;
  - the write appears two cycles after the read, at the same address;
  - `done` follows in the next cycle.

  `mem_lock` is high from the read request through the write, and low in the `done` cycle.
- R5: The memory port is lane-free. A 32-bit access (`mem_dw`=0) carries its value in bits 31:0 of `mem_rdata` and `mem_wdata`, with the upper half of `mem_wdata` zero. Add, or, and and xor store the old value combined with the source value, wrapping at the access width.
- R6: With fetch set, a simple operation raises `wb_src_en` in the `done` cycle, and `wb_data` holds the old value, zero-extended. Without fetch, no write-back enable rises.
- R7: Exchange stores the source value and returns the old value through `wb_src_en` and `wb_data`.
- R8: Compare-and-exchange compares the old value with R0 at the access width. It stores the source value only on a match. It always returns the old value through `wb_r0_en`, never through `wb_src_en`. On a mismatch there is no write, and `done` comes in the third cycle after the `start` edge.
- R9: An erroneous operation raises `done` and `err` in the first cycle after the `start` edge, with no write-back enable.
- R10: A `start` pulse that arrives while an operation is in progress is ignored. No extra memory access results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the operands presented this cycle |
| opcode | input | 8 | Instruction opcode |
| offset | input | 16 | Signed address offset |
| imm | input | 32 | Immediate selecting the atomic operation |
| dst_val | input | 64 | Destination register value (base address) |
| src_val | input | 64 | Source register value (operand) |
| r0_val | input | 64 | R0 value (comparand) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_dw | output | 1 | Access is 64-bit (1) or 32-bit (0) |
| mem_lock | output | 1 | Memory held for this read-modify-write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read request |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Finished operation was rejected |
| wb_src_en | output | 1 | Write `wb_data` into the source register |
| wb_r0_en | output | 1 | Write `wb_data` into R0 |
| wb_data | output | 64 | Old memory value, zero-extended |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request. They also assume that `mem_rdata` is not consulted in any other cycle, and that `start` only begins an operation from idle. The bench memory model responds with that fixed latency and keeps every address inside its 128-byte window by choosing the target address first and then deriving the destination value from the offset. Most random operands are legal encodings. A minority are deliberately misaligned or carry illegal opcodes and immediates, so that the error path is exercised without ever driving an undefined memory response.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  localparam int XLEN  = 64;
  localparam int HLEN  = XLEN / 2;
  localparam int OPC_W = 8;
  localparam int OFF_W = 16;
  localparam int IMM_W = 32;

  localparam logic [2:0] CLS_STORE_REG = 3'd3;
  localparam logic [2:0] MODE_ATOMIC   = 3'd6;
  localparam logic [1:0] SZ_WORD       = 2'd0;
  localparam logic [1:0] SZ_DWORD      = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_WRITE, ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    AOP_ADD, AOP_OR, AOP_AND, AOP_XOR, AOP_SWAP, AOP_CAS
  } aop_t;

  typedef struct packed {
    aop_t op;
    logic fetch;
    logic dw;
    logic legal;
  } adec_t;

  function automatic logic [XLEN-1:0] f_zext(input logic dw, input logic [XLEN-1:0] v);
    return dw ? v : {{HLEN{1'b0}}, v[HLEN-1:0]};
  endfunction

  function automatic adec_t f_decode(input logic [OPC_W-1:0] opc, input logic [IMM_W-1:0] im);
    adec_t d;
    d.legal = 1'b1;
    d.fetch = im[0];
    d.dw    = (opc[4:3] == SZ_DWORD);
    d.op    = AOP_ADD;
    if (opc[2:0] != CLS_STORE_REG || opc[7:5] != MODE_ATOMIC) d.legal = 1'b0;
    if (opc[4:3] != SZ_WORD && opc[4:3] != SZ_DWORD) d.legal = 1'b0;
    if (im[IMM_W-1:8] != '0 || im[3:1] != 3'd0) d.legal = 1'b0;
    case (im[7:4])
      4'h0: d.op = AOP_ADD;
      4'h4: d.op = AOP_OR;
      4'h5: d.op = AOP_AND;
      4'hA: d.op = AOP_XOR;
      4'hE: begin d.op = AOP_SWAP; if (!im[0]) d.legal = 1'b0; end
      4'hF: begin d.op = AOP_CAS;  if (!im[0]) d.legal = 1'b0; end
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic f_aligned(input logic dw, input logic [2:0] lo);
    return dw ? (lo == 3'd0) : (lo[1:0] == 2'd0);
  endfunction

  function automatic logic f_match(input logic dw, input logic [XLEN-1:0] old_v,
                                   input logic [XLEN-1:0] cmp_v);
    return f_zext(dw, old_v) == f_zext(dw, cmp_v);
  endfunction

  function automatic logic [XLEN-1:0] f_apply(input aop_t op, input logic dw,
                                              input logic [XLEN-1:0] old_v,
                                              input logic [XLEN-1:0] src_v);
    logic [XLEN-1:0] a, o, r;
    a = f_zext(dw, src_v);
    o = f_zext(dw, old_v);
    case (op)
      AOP_ADD: r = o + a;
      AOP_OR:  r = o | a;
      AOP_AND: r = o & a;
      AOP_XOR: r = o ^ a;
      default: r = a;
    endcase
    return f_zext(dw, r);
  endfunction
endpackage

// File: rtl/atomic_decode.sv
module atomic_decode
  import atomic_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  output adec_t            dec,
  output logic [XLEN-1:0]  addr,
  output logic             accept
);
  localparam int EXT_W = XLEN - OFF_W;

  always_comb begin
    dec    = f_decode(opcode, imm);
    addr   = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    accept = dec.legal && f_aligned(dec.dw, addr[2:0]);
  end
endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_pkg::*;
(
  input  aop_t            op,
  input  logic            dw,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] cmp_val,
  output logic [XLEN-1:0] new_val,
  output logic            write_en
);
  always_comb begin
    new_val  = f_apply(op, dw, old_val, src_val);
    write_en = (op != AOP_CAS) || f_match(dw, old_val, cmp_val);
  end
endmodule

// File: rtl/atomic_seq.sv
module atomic_seq
  import atomic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       accept,
  input  logic       write_en,
  output seq_state_t state,
  output logic       rd_fire,
  output logic       wr_fire,
  output logic       lock,
  output logic       finish
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start) nxt = accept ? ST_READ : ST_DONE;
      ST_READ:  nxt = ST_WAIT;
      ST_WAIT:  nxt = write_en ? ST_WRITE : ST_DONE;
      ST_WRITE: nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign rd_fire = (state == ST_READ);
  assign wr_fire = (state == ST_WRITE);
  assign lock    = (state == ST_READ) || (state == ST_WAIT) || (state == ST_WRITE);
  assign finish  = (state == ST_DONE);
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic [OFF_W-1:0] offset,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  dst_val,
  input  logic [XLEN-1:0]  src_val,
  input  logic [XLEN-1:0]  r0_val,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_dw,
  output logic             mem_lock,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             done,
  output logic             err,
  output logic             wb_src_en,
  output logic             wb_r0_en,
  output logic [XLEN-1:0]  wb_data
);
  adec_t           dec_in, dec_q;
  logic [XLEN-1:0] addr_in, addr_q, src_q, r0_q, old_q, new_q, old_now, alu_new;
  logic            accept_in, bad_q, alu_wr;
  seq_state_t      state;
  logic            rd_fire, wr_fire, lock, finish, take, skip_write;

  atomic_decode u_dec (
    .opcode(opcode), .imm(imm), .base(dst_val), .offset(offset),
    .dec(dec_in), .addr(addr_in), .accept(accept_in)
  );

  assign old_now = f_zext(dec_q.dw, mem_rdata);

  atomic_alu u_alu (
    .op(dec_q.op), .dw(dec_q.dw), .old_val(old_now), .src_val(src_q),
    .cmp_val(r0_q), .new_val(alu_new), .write_en(alu_wr)
  );

  atomic_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept_in),
    .write_en(alu_wr), .state(state), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .lock(lock), .finish(finish)
  );

  assign take       = start && (state == ST_IDLE);
  assign skip_write = (state == ST_WAIT) && !alu_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= '0;
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
      bad_q  <= 1'b0;
      old_q  <= '0;
      new_q  <= '0;
    end else begin
      if (take) begin
        dec_q  <= dec_in;
        addr_q <= addr_in;
        src_q  <= src_val;
        r0_q   <= r0_val;
        bad_q  <= !accept_in;
        old_q  <= '0;
      end
      if (state == ST_WAIT) begin
        old_q <= old_now;
        new_q <= alu_new;
      end
    end
  end

  assign mem_req   = rd_fire || wr_fire;
  assign mem_we    = wr_fire;
  assign mem_dw    = dec_q.dw;
  assign mem_lock  = lock;
  assign mem_addr  = mem_req ? addr_q : '0;
  assign mem_wdata = wr_fire ? new_q : '0;

  assign done      = finish;
  assign err       = finish && bad_q;
  assign wb_src_en = finish && !bad_q && dec_q.fetch && (dec_q.op != AOP_CAS);
  assign wb_r0_en  = finish && !bad_q && (dec_q.op == AOP_CAS);
  assign wb_data   = (wb_src_en || wb_r0_en) ? old_q : '0;
endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker
  import atomic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_lock,
  input logic [XLEN-1:0] mem_addr,
  input logic            done,
  input logic            err,
  input logic            wb_src_en,
  input logic            wb_r0_en,
  input logic            rd_fire,
  input logic            skip_write
);
  a_r4_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(mem_req, 2) && !$past(mem_we, 2) &&
                             mem_addr == $past(mem_addr, 2)));

  a_r4_wait_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (mem_lock && !mem_req));

  a_r4_done_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_lock);

  a_r9_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !$past(mem_lock));

  a_r9_err_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(wb_src_en || wb_r0_en));

  a_r6_wb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_src_en && wb_r0_en));

  a_r6_wb_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_src_en || wb_r0_en) |-> done);

  a_r8_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    skip_write |=> (done && !mem_req && wb_r0_en));
endmodule

bind atomic_rmw_unit atomic_rmw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_lock(mem_lock), .mem_addr(mem_addr), .done(done), .err(err),
  .wb_src_en(wb_src_en), .wb_r0_en(wb_r0_en), .rd_fire(rd_fire),
  .skip_write(skip_write)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0, src_val = '0, r0_val = '0;
  logic        mem_req, mem_we, mem_dw, mem_lock, done, err, wb_src_en, wb_r0_en;
  logic [63:0] mem_addr, mem_wdata, wb_data;
  logic [63:0] mem_rdata = '0;

  int n_checks = 0, n_fail = 0, n_reads = 0, n_writes = 0;
  logic [63:0] mem [16];

  always #10 clk = ~clk;

  atomic_rmw_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .offset(offset),
    .imm(imm), .dst_val(dst_val), .src_val(src_val), .r0_val(r0_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dw(mem_dw), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err), .wb_src_en(wb_src_en), .wb_r0_en(wb_r0_en),
    .wb_data(wb_data)
  );

  // memory model: one-cycle read latency, lane-free 32-bit accesses
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= {32'h9E37_79B9 * (i + 1), 32'h0F0F_0000 + i};
    end else if (mem_req) begin
      if (mem_we) begin
        n_writes <= n_writes + 1;
        if (mem_dw) mem[mem_addr[6:3]] <= mem_wdata;
        else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
        else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
      end else begin
        n_reads <= n_reads + 1;
        if (mem_dw) mem_rdata <= mem[mem_addr[6:3]];
        else mem_rdata <= {32'h0, mem_addr[2] ? mem[mem_addr[6:3]][63:32] : mem[mem_addr[6:3]][31:0]};
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] z32(input bit dw, input logic [63:0] v);
    return dw ? v : {32'h0, v[31:0]};
  endfunction

  task automatic run_op(input logic [7:0] opc, input logic [15:0] off, input logic [31:0] im,
                        input logic [63:0] dst, input logic [63:0] src, input logic [63:0] r0,
                        input bit poke);
    logic [63:0] addr, word, old, nv, sv, rv, expw;
    bit dw, ok_opc, ok_imm, ok_al, ok, wr, is_cas;
    int lat, r_before, w_before, exp_lat;
    addr   = dst + {{48{off[15]}}, off};
    ok_opc = (opc == 8'hC3) || (opc == 8'hDB);
    dw     = (opc == 8'hDB);
    ok_imm = (im[31:8] == 24'h0) && (im[7:0] inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50,
                                                      8'h51, 8'hA0, 8'hA1, 8'hE1, 8'hF1});
    ok_al  = dw ? (addr[2:0] == 3'd0) : (addr[1:0] == 2'd0);
    ok     = ok_opc && ok_imm && ok_al;
    is_cas = (im[7:4] == 4'hF);
    word   = mem[addr[6:3]];
    old    = dw ? word : {32'h0, addr[2] ? word[63:32] : word[31:0]};
    sv     = z32(dw, src);
    rv     = z32(dw, r0);
    wr     = !(is_cas && old != rv);
    case (im[7:4])
      4'h0: nv = old + sv;
      4'h4: nv = old | sv;
      4'h5: nv = old & sv;
      4'hA: nv = old ^ sv;
      default: nv = sv;
    endcase
    nv = z32(dw, nv);
    expw = word;
    if (ok && wr) begin
      if (dw) expw = nv;
      else if (addr[2]) expw[63:32] = nv[31:0];
      else expw[31:0] = nv[31:0];
    end
    exp_lat = !ok ? 1 : (wr ? 4 : 3);
    r_before = n_reads; w_before = n_writes;

    @(negedge clk);
    opcode = opc; offset = off; imm = im; dst_val = dst; src_val = src; r0_val = r0; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (poke && lat == 2) begin
        start = 1'b1; opcode = 8'hDB; imm = 32'h0; dst_val = 64'h40; offset = '0;
      end
    end while (!done && lat < 20);
    start = 1'b0;

    check(lat == exp_lat, ok ? (is_cas && !wr ? "R8 latency" : "R4 latency") : "R9 latency",
          64'(lat), 64'(exp_lat));
    check(err == !ok, !ok_opc ? "R1 err" : (!ok_imm ? "R2 err" : "R3 err"), 64'(err), 64'(!ok));
    check(wb_src_en == (ok && im[0] && !is_cas), "R6 wb_src_en", 64'(wb_src_en), 64'(ok && im[0] && !is_cas));
    check(wb_r0_en == (ok && is_cas), "R8 wb_r0_en", 64'(wb_r0_en), 64'(ok && is_cas));
    if (wb_src_en || wb_r0_en)
      check(wb_data == old, im[7:4] == 4'hE ? "R7 old value" : "R6 old value", wb_data, old);
    @(negedge clk);
    check(n_reads - r_before == (ok ? 1 : 0), poke ? "R10 reads" : "R3 reads",
          64'(n_reads - r_before), 64'(ok ? 1 : 0));
    check(n_writes - w_before == ((ok && wr) ? 1 : 0), "R8 writes",
          64'(n_writes - w_before), 64'((ok && wr) ? 1 : 0));
    check(mem[addr[6:3]] == expw, im[7:4] == 4'hE ? "R7 memory" : "R5 memory", mem[addr[6:3]], expw);
    check(!mem_lock && !done, "R4 idle after", 64'({mem_lock, done}), 64'h0);
  endtask

  function automatic logic [31:0] pick_imm(input int k);
    case (k)
      0: return 32'h00; 1: return 32'h01; 2: return 32'h40; 3: return 32'h41;
      4: return 32'h50; 5: return 32'h51; 6: return 32'hA0; 7: return 32'hA1;
      8: return 32'hE1; 9: return 32'hF1; 10: return 32'hE0; 11: return 32'h02;
      default: return 32'h0000_0141;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !mem_lock && !done && !err, "R4 reset state",
          64'({mem_req, mem_lock, done, err}), 64'h0);

    // directed corner cases
    run_op(8'hDB, 16'h0000, 32'h01, 64'h10, 64'h5, 64'h0, 0);               // R5/R6 64-bit fetch add
    run_op(8'hC3, 16'h0004, 32'h00, 64'h20, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);  // R5 32-bit wrap, upper half
    run_op(8'hDB, 16'hFFF8, 32'hE1, 64'h38, 64'hCAFE, 0, 0);                // R7 negative offset
    run_op(8'hC3, 16'h0000, 32'hF1, 64'h08, 64'h77, 64'h0F0F_0001, 0);       // R8 match low word
    run_op(8'hDB, 16'h0000, 32'hF1, 64'h18, 64'h77, 64'h1, 0);              // R8 mismatch
    run_op(8'hD3, 16'h0000, 32'h00, 64'h08, 64'h1, 0, 0);                   // R1 byte size
    run_op(8'hCB, 16'h0000, 32'h00, 64'h08, 64'h1, 0, 0);                   // R1 half size
    run_op(8'hDB, 16'h0000, 32'hE0, 64'h08, 64'h1, 0, 0);                   // R2 swap without fetch
    run_op(8'hDB, 16'h0000, 32'h0000_0100, 64'h08, 64'h1, 0, 0);            // R2 upper bits
    run_op(8'hDB, 16'h0004, 32'h00, 64'h08, 64'h1, 0, 0);                   // R3 misaligned 64-bit
    run_op(8'hC3, 16'h0002, 32'h00, 64'h08, 64'h1, 0, 0);                   // R3 misaligned 32-bit
    run_op(8'hDB, 16'h0000, 32'hA1, 64'h30, 64'hF0F0, 0, 1);                // R10 start while busy

    for (int n = 0; n < 300; n++) begin
      logic [63:0] a, s, r;
      logic [15:0] off;
      logic [7:0]  opc;
      int k;
      k   = $urandom_range(0, 19);
      opc = (k < 17) ? (($urandom_range(0, 1) != 0) ? 8'hDB : 8'hC3)
                     : ((k == 17) ? 8'hD3 : ((k == 18) ? 8'hCB : 8'hC2));
      a   = {57'h0, 7'($urandom_range(0, 127))};
      if ($urandom_range(0, 9) != 0) a[2:0] = (opc == 8'hDB) ? 3'd0 : {a[2], 2'd0};
      off = 16'($signed($urandom_range(0, 127)) - 64);
      s   = {$urandom, $urandom};
      if ($urandom_range(0, 1) != 0) begin
        r = mem[a[6:3]];
        if (opc != 8'hDB && a[2]) r = {$urandom, r[63:32]};
      end else r = {$urandom, $urandom};
      run_op(opc, off, pick_imm(($urandom_range(0, 9) != 0) ? $urandom_range(0, 9) : $urandom_range(10, 12)),
             a - {{48{off[15]}}, off}, s, r, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule